// File: doc/BRIEF.md
# SD card identification sequencer

This block takes an SD card from power-up to the transfer state by driving a separate command path engine one command at a time. It issues a start pulse with an index, an argument and response flags, then waits for the engine to report completion with a pass flag and the 32-bit short-response field. The steps run in a fixed order: go-idle, interface-condition check, a polled operating-condition request with a deadline, CID readout, relative address request, CSD readout and card selection.

While it runs, the block holds the card clock selection at the identification rate. When the card has been selected, it moves the clock to an operating rate chosen by a configuration input. It then raises a ready flag and reports whether the card is high capacity. Any fatal step ends the run with a small error code. A new start pulse begins a fresh attempt.

Top module: `sd_ident_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, ready_o=0, err_o=0, clk_div_o=0 (identification rate) and cmd_start_o=0.
- R2: A start_i pulse while idle, done or failed makes busy_o=1 in the next cycle and issues index 0 with argument 0 and no response. start_i while busy has no effect on the command order. clk_div_o stays 0 for as long as busy_o=1.
- R3: Each command is a single-cycle cmd_start_o pulse. cmd_idx_o, cmd_arg_o, cmd_resp_o and cmd_long_o stay stable until cmd_done_i.
- R4: Index 8 is issued with argument 0x1AA and a short response. The card is marked version 2 only if cmd_ok_i=1 and response bits 11:0 equal 0x1AA. A failure at this step is not an error.
- R5: Every index-41 request is preceded by index 55 (argument 0, short response), whose outcome is ignored. The index-41 argument is 0x00FF8000, with bit 30 also set only for version 2 cards.
- R6: Polling stops only when index 41 returns cmd_ok_i=1 with response bit 31 set. hc_o then equals response bit 30 and is valid while ready_o=1.
- R7: If index 41 completes without the ready bit after TIMEOUT_CYC cycles of polling, the run stops with err_o=2. Polling that finishes earlier succeeds.
- R8: Index 2 (argument 0, long response) is followed by index 3 (argument 0, short), which stores response bits 31:16 as the card address. Index 9 (long) and then index 7 (no response) carry that address in argument bits 31:16, with zeros below.
- R9: A failed step stops the run with busy_o=0 and no further commands. The codes are 1 for index 0, 3 for index 2, 4 for index 3, 5 for index 9 and 6 for index 7.
- R10: After a successful selection ready_o=1 and clk_div_o follows op_speed_i: 0 gives 1 (full), 1 gives 2 (half), 2 or 3 give 3 (quarter).
- R11: A restart from the done or failed state clears ready_o, err_o and clk_div_o to 0.
- R12: ready_o=1 and a nonzero err_o never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an identification run |
| op_speed_i | input | 2 | Operating clock choice: 0 full, 1 half, 2/3 quarter |
| cmd_start_o | output | 1 | One-cycle request to the command engine |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_resp_o | output | 1 | Command expects a response |
| cmd_long_o | output | 1 | Response is long (136-bit) |
| cmd_done_i | input | 1 | Engine finished the current command |
| cmd_ok_i | input | 1 | Command sent and response (if any) passed checks |
| cmd_resp_i | input | 32 | Short-response field from the engine |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Card is in transfer state |
| hc_o | output | 1 | Card is high capacity (block addressed) |
| err_o | output | 3 | Error code, 0 when none |
| clk_div_o | output | 2 | Card clock select: 0 ident, 1 full, 2 half, 3 quarter |
| rca_o | output | 16 | Relative card address |

## Verification
The assertions assume that the command engine raises cmd_done_i only after a request has been issued, and only once for each request. The bench model follows this rule: it waits for each cmd_start_o pulse, holds for two cycles, then gives a single done pulse. The timeout assertion assumes the polling loop is the only path where the deadline counter runs. The stimulus sweeps every operating speed, three interface-check outcomes, both capacity bits and several poll counts, and fails each fatal step in turn.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_IFC, ST_APP, ST_OPC,
    ST_CID, ST_RCA, ST_CSD, ST_SEL, ST_DONE, ST_FAIL
  } sdi_state_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_RESET = 3'd1, ERR_TIMEOUT = 3'd2, ERR_CID = 3'd3,
    ERR_RCA = 3'd4, ERR_CSD = 3'd5, ERR_SEL = 3'd6
  } sdi_err_e;

  typedef enum logic [1:0] {
    CLK_IDENT = 2'd0, CLK_FULL = 2'd1, CLK_HALF = 2'd2, CLK_QUARTER = 2'd3
  } sdi_clk_e;

  localparam int IDX_W = 6;
  localparam int ARG_W = 32;
  localparam int RCA_W = 16;
  localparam logic [ARG_W-1:0] IFC_ARG  = 32'h0000_01AA;
  localparam logic [11:0]      IFC_ECHO = 12'h1AA;
  localparam logic [ARG_W-1:0] OPC_ARG  = 32'h00FF_8000;
  localparam int OCR_BUSY_BIT = 31;
  localparam int OCR_HCS_BIT  = 30;
endpackage

// File: rtl/sdi_deadline.sv
module sdi_deadline #(
  parameter int unsigned LIMIT = 1000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic run_i,
  output logic expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (arm_i)                          cnt_q <= '0;
    else if (run_i && cnt_q != W'(LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == W'(LIMIT));

  // R7
  expired_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !arm_i) |=> expired_o);
endmodule

// File: rtl/sdi_clk_sel.sv
module sdi_clk_sel
  import sdi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ident_i,
  input  logic       op_i,
  input  logic [1:0] speed_i,
  output sdi_clk_e   div_o
);
  sdi_clk_e op_sel;

  always_comb begin
    unique case (speed_i)
      2'd0:    op_sel = CLK_FULL;
      2'd1:    op_sel = CLK_HALF;
      default: op_sel = CLK_QUARTER;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_o <= CLK_IDENT;
    else if (ident_i) div_o <= CLK_IDENT;
    else if (op_i)    div_o <= op_sel;
  end

  // R10
  op_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && !ident_i) |=> div_o != CLK_IDENT);
endmodule

// File: rtl/sdi_cmd_fmt.sv
module sdi_cmd_fmt
  import sdi_pkg::*;
(
  input  sdi_state_e        state_i,
  input  logic              v2_i,
  input  logic [RCA_W-1:0]  rca_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic              resp_o,
  output logic              long_o
);
  logic [ARG_W-1:0] rca_arg;
  assign rca_arg = {rca_i, {(ARG_W-RCA_W){1'b0}}};

  always_comb begin
    idx_o  = '0;
    arg_o  = '0;
    resp_o = 1'b0;
    long_o = 1'b0;
    unique case (state_i)
      ST_IFC: begin idx_o = 6'd8;  arg_o = IFC_ARG; resp_o = 1'b1; end
      ST_APP: begin idx_o = 6'd55; resp_o = 1'b1; end
      ST_OPC: begin
        idx_o  = 6'd41;
        arg_o  = OPC_ARG;
        arg_o[OCR_HCS_BIT] = v2_i;
        resp_o = 1'b1;
      end
      ST_CID: begin idx_o = 6'd2; resp_o = 1'b1; long_o = 1'b1; end
      ST_RCA: begin idx_o = 6'd3; resp_o = 1'b1; end
      ST_CSD: begin idx_o = 6'd9; arg_o = rca_arg; resp_o = 1'b1; long_o = 1'b1; end
      ST_SEL: begin idx_o = 6'd7; arg_o = rca_arg; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq
  import sdi_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 250_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_speed_i,
  output logic        cmd_start_o,
  output logic [5:0]  cmd_idx_o,
  output logic [31:0] cmd_arg_o,
  output logic        cmd_resp_o,
  output logic        cmd_long_o,
  input  logic        cmd_done_i,
  input  logic        cmd_ok_i,
  input  logic [31:0] cmd_resp_i,
  output logic        busy_o,
  output logic        ready_o,
  output logic        hc_o,
  output logic [2:0]  err_o,
  output logic [1:0]  clk_div_o,
  output logic [15:0] rca_o
);
  sdi_state_e state_q;
  sdi_err_e   err_q;
  logic       issued_q, v2_q, hc_q;
  logic [RCA_W-1:0] rca_q;
  logic       in_step, start_go, fin, expired, op_go;
  sdi_clk_e   div;

  assign in_step  = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign start_go = start_i && !in_step;
  assign fin      = in_step && issued_q && cmd_done_i;
  assign op_go    = fin && state_q == ST_SEL && cmd_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; err_q <= ERR_NONE; issued_q <= 1'b0;
      v2_q <= 1'b0; hc_q <= 1'b0; rca_q <= '0;
    end else if (start_go) begin
      state_q <= ST_RST; err_q <= ERR_NONE; issued_q <= 1'b0;
      v2_q <= 1'b0; hc_q <= 1'b0; rca_q <= '0;
    end else if (in_step && !issued_q) begin
      issued_q <= 1'b1;
    end else if (fin) begin
      issued_q <= 1'b0;
      unique case (state_q)
        ST_RST: if (cmd_ok_i) state_q <= ST_IFC;
                else begin state_q <= ST_FAIL; err_q <= ERR_RESET; end
        ST_IFC: begin
          v2_q    <= cmd_ok_i && cmd_resp_i[11:0] == IFC_ECHO;
          state_q <= ST_APP;
        end
        ST_APP: state_q <= ST_OPC;
        ST_OPC:
          if (cmd_ok_i && cmd_resp_i[OCR_BUSY_BIT]) begin
            hc_q <= cmd_resp_i[OCR_HCS_BIT]; state_q <= ST_CID;
          end else if (expired) begin
            state_q <= ST_FAIL; err_q <= ERR_TIMEOUT;
          end else state_q <= ST_APP;
        ST_CID: if (cmd_ok_i) state_q <= ST_RCA;
                else begin state_q <= ST_FAIL; err_q <= ERR_CID; end
        ST_RCA: if (cmd_ok_i) begin
                  rca_q <= cmd_resp_i[31:32-RCA_W]; state_q <= ST_CSD;
                end else begin state_q <= ST_FAIL; err_q <= ERR_RCA; end
        ST_CSD: if (cmd_ok_i) state_q <= ST_SEL;
                else begin state_q <= ST_FAIL; err_q <= ERR_CSD; end
        ST_SEL: if (cmd_ok_i) state_q <= ST_DONE;
                else begin state_q <= ST_FAIL; err_q <= ERR_SEL; end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sdi_deadline #(.LIMIT(TIMEOUT_CYC)) u_deadline (
    .clk_i, .rst_ni,
    .arm_i     (state_q == ST_IFC),
    .run_i     (state_q inside {ST_APP, ST_OPC}),
    .expired_o (expired)
  );

  sdi_clk_sel u_clk_sel (
    .clk_i, .rst_ni,
    .ident_i (start_go),
    .op_i    (op_go),
    .speed_i (op_speed_i),
    .div_o   (div)
  );

  sdi_cmd_fmt u_fmt (
    .state_i (state_q),
    .v2_i    (v2_q),
    .rca_i   (rca_q),
    .idx_o   (cmd_idx_o),
    .arg_o   (cmd_arg_o),
    .resp_o  (cmd_resp_o),
    .long_o  (cmd_long_o)
  );

  assign cmd_start_o = in_step && !issued_q;
  assign busy_o      = in_step;
  assign ready_o     = (state_q == ST_DONE);
  assign hc_o        = hc_q;
  assign err_o       = err_q;
  assign clk_div_o   = div;
  assign rca_o       = rca_q;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o);
  // R3
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmd_start_o && !cmd_done_i) |=> $stable(cmd_idx_o) && $stable(cmd_arg_o));
  // R2
  ident_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> clk_div_o == 2'd0);
  // R2
  first_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cmd_start_o && cmd_idx_o == 6'd0 && !cmd_resp_o);
  // R12
  ready_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && err_o != 3'd0));
  // R9
  quiet_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 3'd0) |-> !cmd_start_o);
endmodule

// File: tb/sd_ident_seq_tb.sv
`timescale 1ns/1ps
module sd_ident_seq_tb;
  localparam int unsigned TMO = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_speed_i = 2'd0;
  logic cmd_start_o, cmd_resp_o, cmd_long_o;
  logic [5:0] cmd_idx_o;
  logic [31:0] cmd_arg_o;
  logic cmd_done_i = 1'b0, cmd_ok_i = 1'b0;
  logic [31:0] cmd_resp_i = '0;
  logic busy_o, ready_o, hc_o;
  logic [2:0] err_o;
  logic [1:0] clk_div_o;
  logic [15:0] rca_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  sd_ident_seq #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .op_speed_i,
    .cmd_start_o, .cmd_idx_o, .cmd_arg_o, .cmd_resp_o, .cmd_long_o,
    .cmd_done_i, .cmd_ok_i, .cmd_resp_i,
    .busy_o, .ready_o, .hc_o, .err_o, .clk_div_o, .rca_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic serve(input int idx, input logic [31:0] arg, input bit rsp, input bit lng,
                       input bit ok, input logic [31:0] rdata, input string req, input bit poke);
    int g = 0;
    while (!cmd_start_o && g < 50) begin @(negedge clk); g++; end
    chk("R3", "start pulse", 32'(cmd_start_o), 32'd1);
    chk(req, "index", 32'(cmd_idx_o), 32'(idx));
    chk(req, "argument", cmd_arg_o, arg);
    chk(req, "resp flags", {30'd0, cmd_resp_o, cmd_long_o}, {30'd0, rsp, lng});
    @(negedge clk);
    chk("R3", "single cycle start", 32'(cmd_start_o), 32'd0);
    if (poke) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R3", "held index", 32'(cmd_idx_o), 32'(idx));
    chk("R3", "held argument", cmd_arg_o, arg);
    cmd_done_i = 1'b1; cmd_ok_i = ok; cmd_resp_i = rdata;
    @(negedge clk);
    cmd_done_i = 1'b0; cmd_ok_i = 1'b0; cmd_resp_i = '0;
  endtask

  task automatic kick();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2", "busy after start", 32'(busy_o), 32'd1);
    chk("R11", "err cleared", 32'(err_o), 32'd0);
    chk("R11", "ready cleared", 32'(ready_o), 32'd0);
    chk("R11", "clock back to ident", 32'(clk_div_o), 32'd0);
  endtask

  task automatic expect_fail(input logic [2:0] code, input string req);
    chk(req, "busy dropped", 32'(busy_o), 32'd0);
    chk(req, "error code", 32'(err_o), 32'(code));
    chk("R12", "no ready on error", 32'(ready_o), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R9", "no further command", 32'(cmd_start_o), 32'd0);
    end
  endtask

  // cmd8_mode: 0 echo 1AA, 1 wrong echo, 2 no response
  task automatic run_seq(input int cmd8_mode, input int npoll, input bit hc, input int fail_at,
                         input logic [1:0] spd, input logic [15:0] rca, input bit poke);
    bit v2;
    logic [31:0] oarg;
    logic [31:0] rarg;
    op_speed_i = spd;
    kick();
    serve(0, 32'h0, 0, 0, fail_at != 1, 32'h0, "R2", 1'b0);
    if (fail_at == 1) begin expect_fail(3'd1, "R9"); return; end
    serve(8, 32'h1AA, 1, 0, cmd8_mode != 2, (cmd8_mode == 1) ? 32'h2AA : 32'h1AA, "R4", poke);
    v2 = (cmd8_mode == 0);
    oarg = 32'h00FF8000 | (v2 ? 32'h4000_0000 : 32'h0);
    for (int i = 0; i <= npoll; i++) begin
      bit last = (i == npoll);
      bit ok = last ? 1'b1 : (i % 2 == 0);
      logic [31:0] rd = last ? {1'b1, hc, 30'h0} : (ok ? 32'h0 : 32'h8000_0000);
      serve(55, 32'h0, 1, 0, i % 3 != 1, 32'h0, "R5", 1'b0);
      serve(41, oarg, 1, 0, ok, rd, last ? "R6" : "R5", 1'b0);
    end
    serve(2, 32'h0, 1, 1, fail_at != 3, 32'h0, "R8", poke);
    if (fail_at == 3) begin expect_fail(3'd3, "R9"); return; end
    serve(3, 32'h0, 1, 0, fail_at != 4, {rca, 16'h0}, "R8", 1'b0);
    if (fail_at == 4) begin expect_fail(3'd4, "R9"); return; end
    rarg = {rca, 16'h0};
    serve(9, rarg, 1, 1, fail_at != 5, 32'h0, "R8", 1'b0);
    if (fail_at == 5) begin expect_fail(3'd5, "R9"); return; end
    serve(7, rarg, 0, 0, fail_at != 6, 32'h0, "R8", 1'b0);
    if (fail_at == 6) begin expect_fail(3'd6, "R9"); return; end
    chk("R10", "ready", 32'(ready_o), 32'd1);
    chk("R12", "err none on ready", 32'(err_o), 32'd0);
    chk("R6", "high capacity", 32'(hc_o), 32'(hc));
    chk("R8", "card address", 32'(rca_o), 32'(rca));
    chk("R10", "operating clock", 32'(clk_div_o), (spd == 2'd0) ? 32'd1 : (spd == 2'd1) ? 32'd2 : 32'd3);
  endtask

  task automatic run_timeout(input int cmd8_mode);
    int rounds = 0;
    kick();
    serve(0, 32'h0, 0, 0, 1, 32'h0, "R2", 1'b0);
    serve(8, 32'h1AA, 1, 0, cmd8_mode != 2, 32'h1AA, "R4", 1'b0);
    while (rounds < 200) begin
      serve(55, 32'h0, 1, 0, 1, 32'h0, "R5", 1'b0);
      serve(41, (cmd8_mode == 0) ? 32'h40FF8000 : 32'h00FF8000, 1, 0, 1, 32'h0, "R7", 1'b0);
      rounds++;
      if (!busy_o) break;
    end
    // each poll round takes six cycles; expiry lands after about TMO/6 rounds
    chk("R7", "rounds before timeout", 32'(rounds >= 25 && rounds <= 45), 32'd1);
    expect_fail(3'd2, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy_o), 32'd0);
    chk("R1", "ready in reset", 32'(ready_o), 32'd0);
    chk("R1", "err in reset", 32'(err_o), 32'd0);
    chk("R1", "clock in reset", 32'(clk_div_o), 32'd0);
    chk("R1", "no start in reset", 32'(cmd_start_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", 32'(busy_o | cmd_start_o), 32'd0);
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 3; m++)
        for (int h = 0; h < 2; h++)
          run_seq(m, (s + m + h) % 4, h[0], 0, 2'(s), 16'h1234 + 16'(s * 97 + m * 13 + h), 1'b0);
    run_seq(0, 1, 1'b1, 0, 2'd1, 16'hBEEF, 1'b1);
    run_seq(0, 20, 1'b0, 0, 2'd0, 16'h0F0F, 1'b0);
    run_seq(1, 0, 1'b0, 1, 2'd2, 16'h0001, 1'b0);
    run_seq(0, 2, 1'b1, 3, 2'd0, 16'h0002, 1'b0);
    run_seq(2, 1, 1'b0, 4, 2'd1, 16'h0003, 1'b0);
    run_seq(0, 0, 1'b1, 5, 2'd3, 16'h0004, 1'b0);
    run_seq(1, 3, 1'b0, 6, 2'd2, 16'h0005, 1'b0);
    run_timeout(0);
    run_timeout(2);
    run_seq(0, 0, 1'b1, 0, 2'd2, 16'hCAFE, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule